// File: doc/BRIEF.md
# Receive frame FIFO unpacker

This block sits on the read side of a receive frame FIFO. It reads 16-bit entries that each carry a 2-bit byte-valid tag and turns them into a byte stream with start and end markers. Frame boundaries and per-frame status are not signalled on separate pins. Every frame is closed by an in-band status word that carries a tag value frame data never uses. The status word reports whether the frame was good or bad, and whether the FIFO filled up while the frame was being written. Bad frames sit in the FIFO like any others, so the unpacker reads the status word to tell them apart.

The FIFO answers a read request one clock later. It either acknowledges with data or raises an error pulse when it was empty. The unpacker keeps at most one request in flight. It holds back the most recent data byte until the next entry shows whether that byte ends the frame. End-of-frame and the three status bits then appear together on that final byte. A frame with no data bytes produces one zero-length end marker.

In the optional drop mode, the bytes of each frame are kept in an internal buffer of `BUF_BYTES` bytes until the status word arrives. A frame whose status has the bad or overflow bit set is then discarded whole. The mode pin is sampled between frames.

The byte output is valid/ready:
- A beat transfers on a clock edge where both `out_valid` and `out_ready` are high.
- While `out_valid` is high and `out_ready` is low, the beat and its flags are held unchanged.
- `out_valid` never waits for `out_ready`.

Top module: `rxq_unpacker`

## Requirements
- R1: While `rst` is high (synchronous, active high), `out_valid` and `fifo_rd_req` are low. After reset the first beat carries the start flag.
- R2: `fifo_rd_req` is never high on two consecutive cycles. It is never high while `out_valid` is high, so no new read starts while unpacked bytes wait for the consumer.
- R3: An entry is used only in the cycle after a request, when `fifo_rd_ack` is high and `fifo_rd_err` is low. Tag bit 0 qualifies data bits 7:0, which are output first. Tag bit 1 qualifies bits 15:8, which are output second. Tag 2'b01 gives one byte, tag 2'b11 gives two, and tag 2'b00 is skipped.
- R4: Tag 2'b10 marks the status word that closes a frame: bit 15 good, bit 14 bad, bit 13 overflow. `out_eof` and these bits (`out_good`, `out_bad`, `out_ovf`) appear on the frame's final beat. All three status outputs are 0 on every other beat.
- R5: `out_sof` is high on the first beat after reset and on the first beat after every beat with `out_eof`, and low otherwise.
- R6: A frame with no data bytes produces a single beat with `out_zlen`, `out_sof` and `out_eof` high, `out_byte` equal to 0, and the frame's status.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte` and all flags stay unchanged on the next cycle.
- R8: An error pulse or a missing acknowledge produces no byte. The beats on the output are exactly the data bytes of the frames read, plus the zero-length markers.
- R9: With `drop_bad_mode` high at the start of a frame, a frame of at most `BUF_BYTES`-2 data bytes whose status has bit 14 or bit 13 set produces no beat at all. Good frames are delivered complete.
- R10: In drop mode, a frame of more than `BUF_BYTES`-2 data bytes cannot be held whole. It is delivered in full with its status whatever that status is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| drop_bad_mode | input | 1 | Discard bad/overflow frames; sampled between frames |
| fifo_rd_req | output | 1 | Read request to the FIFO |
| fifo_rd_ack | input | 1 | Entry returned, one cycle after a request |
| fifo_rd_err | input | 1 | Request found the FIFO empty, one cycle after a request |
| fifo_rd_data | input | 16 | Entry data |
| fifo_rd_tag | input | 2 | Entry byte-valid tag |
| out_valid | output | 1 | Beat available |
| out_ready | input | 1 | Consumer accepts the beat |
| out_byte | output | 8 | Data byte (0 on a zero-length marker) |
| out_sof | output | 1 | First beat of a frame |
| out_eof | output | 1 | Last beat of a frame |
| out_zlen | output | 1 | Zero-length end marker, carries no data |
| out_good | output | 1 | Good-frame status, on the last beat only |
| out_bad | output | 1 | Bad-frame status, on the last beat only |
| out_ovf | output | 1 | FIFO-filled status, on the last beat only |

## Verification
The hardest situation to reach is a drop-mode frame that is too long for the internal buffer and ends with a bad status. It forces the switch from holding the frame to streaming it, which happens in the middle of the frame. The bench uses an 8-byte buffer and sweeps every frame length from 0 to 11 against all eight status patterns, in both modes, so frames cross the `BUF_BYTES`-2 limit under every status. Skip entries, empty-FIFO error pulses and several ready patterns are mixed into the same runs. They make the release of the held-back byte coincide with stalls on both sides.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // byte-valid tag of a FIFO entry
  typedef enum logic [1:0] {
    TAG_NONE = 2'b00,   // nothing valid, skipped
    TAG_LO   = 2'b01,   // only bits 7:0 valid
    TAG_STAT = 2'b10,   // end-of-frame status word
    TAG_BOTH = 2'b11    // both bytes valid
  } rxq_tag_e;

  typedef struct packed {
    logic good;
    logic bad;
    logic ovf;
  } rxq_stat_t;

  localparam int STAT_GOOD_BIT = 15;
  localparam int STAT_BAD_BIT  = 14;
  localparam int STAT_OVF_BIT  = 13;

endpackage

// File: rtl/rxq_entry_decode.sv
module rxq_entry_decode
  import rxq_pkg::*;
(
  input  logic        ack,
  input  logic        err,
  input  logic [15:0] data,
  input  logic [1:0]  tag,
  output logic [1:0]  byte_cnt,
  output logic [7:0]  byte_lo,
  output logic [7:0]  byte_hi,
  output logic        is_stat,
  output rxq_stat_t   stat
);

  logic     take;
  rxq_tag_e tag_e;

  assign take  = ack & ~err;
  assign tag_e = rxq_tag_e'(tag);

  always_comb begin
    byte_cnt = 2'd0;
    is_stat  = 1'b0;
    if (take) begin
      case (tag_e)
        TAG_LO:   byte_cnt = 2'd1;
        TAG_BOTH: byte_cnt = 2'd2;
        TAG_STAT: is_stat  = 1'b1;
        default:  byte_cnt = 2'd0;
      endcase
    end
  end

  assign byte_lo   = data[7:0];
  assign byte_hi   = data[15:8];
  assign stat.good = data[STAT_GOOD_BIT];
  assign stat.bad  = data[STAT_BAD_BIT];
  assign stat.ovf  = data[STAT_OVF_BIT];

endmodule

// File: rtl/rxq_rd_issue.sv
module rxq_rd_issue (
  input  logic clk,
  input  logic rst,
  input  logic want,
  output logic req,
  output logic pend
);

  assign req = want & ~pend & ~rst;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= req;
  end

endmodule

// File: rtl/rxq_byte_ram.sv
module rxq_byte_ram #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_a,
  input  logic [AW-1:0] addr_a,
  input  logic [7:0]    din_a,
  input  logic          we_b,
  input  logic [AW-1:0] addr_b,
  input  logic [7:0]    din_b,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    dout
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_a) mem[addr_a] <= din_a;
    if (we_b) mem[addr_b] <= din_b;
  end

  assign dout = mem[raddr];

endmodule

// File: rtl/rxq_unpacker.sv
module rxq_unpacker
  import rxq_pkg::*;
#(
  parameter int BUF_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        drop_bad_mode,
  output logic        fifo_rd_req,
  input  logic        fifo_rd_ack,
  input  logic        fifo_rd_err,
  input  logic [15:0] fifo_rd_data,
  input  logic [1:0]  fifo_rd_tag,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_byte,
  output logic        out_sof,
  output logic        out_eof,
  output logic        out_zlen,
  output logic        out_good,
  output logic        out_bad,
  output logic        out_ovf
);

  localparam int AW = $clog2(BUF_BYTES);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CAP = PW'(BUF_BYTES);

  // pointers carry one wrap bit above the address
  logic [PW-1:0] wr_p, rd_p, rel_p;
  logic [PW-1:0] occ, free_sl;
  logic          closed, fr_any, drop_cur, spill, sof_pend;
  rxq_stat_t     st_q;

  logic          pend, want, holding, spill_go, take_beat;
  logic [1:0]    byte_cnt;
  logic [7:0]    byte_lo, byte_hi, ram_q;
  logic          is_stat;
  rxq_stat_t     stat_in;
  logic [PW-1:0] wr_next;

  rxq_entry_decode u_dec (
    .ack      (fifo_rd_ack),
    .err      (fifo_rd_err),
    .data     (fifo_rd_data),
    .tag      (fifo_rd_tag),
    .byte_cnt (byte_cnt),
    .byte_lo  (byte_lo),
    .byte_hi  (byte_hi),
    .is_stat  (is_stat),
    .stat     (stat_in)
  );

  rxq_rd_issue u_issue (
    .clk  (clk),
    .rst  (rst),
    .want (want),
    .req  (fifo_rd_req),
    .pend (pend)
  );

  rxq_byte_ram #(.DEPTH(BUF_BYTES)) u_ram (
    .clk    (clk),
    .we_a   (byte_cnt != 2'd0),
    .addr_a (wr_p[AW-1:0]),
    .din_a  (byte_lo),
    .we_b   (byte_cnt == 2'd2),
    .addr_b (wr_p[AW-1:0] + AW'(1)),
    .din_b  (byte_hi),
    .raddr  (rd_p[AW-1:0]),
    .dout   (ram_q)
  );

  assign occ     = wr_p - rd_p;
  assign free_sl = CAP - occ;
  assign wr_next = wr_p + PW'(byte_cnt);

  // frame is being held whole until its status is known
  assign holding = drop_cur & ~spill;

  // read only when the previous frame is fully drained; streaming
  // frames also wait until every released byte is taken
  assign want = ~closed & (holding ? (free_sl >= PW'(2)) : (rel_p == rd_p));

  // a held frame that no longer fits falls back to streaming
  assign spill_go = holding & ~closed & ~pend & fr_any & (free_sl < PW'(2));

  // output beat
  assign out_valid = (rd_p != rel_p) | closed;
  assign out_zlen  = closed & (rd_p == rel_p);
  assign out_eof   = out_zlen | (closed & ((rel_p - rd_p) == PW'(1)));
  assign out_sof   = sof_pend & out_valid;
  assign out_byte  = out_zlen ? 8'h00 : ram_q;
  assign out_good  = out_eof & st_q.good;
  assign out_bad   = out_eof & st_q.bad;
  assign out_ovf   = out_eof & st_q.ovf;
  assign take_beat = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_p     <= '0;
      rd_p     <= '0;
      rel_p    <= '0;
      closed   <= 1'b0;
      fr_any   <= 1'b0;
      drop_cur <= 1'b0;
      spill    <= 1'b0;
      sof_pend <= 1'b1;
      st_q     <= '0;
    end else begin
      if (take_beat) begin
        if (!out_zlen) rd_p <= rd_p + PW'(1);
        if (out_eof)   closed <= 1'b0;
        sof_pend <= out_eof;
      end

      if (!fr_any && !closed && !pend) drop_cur <= drop_bad_mode;

      if (spill_go) begin
        spill <= 1'b1;
        rel_p <= wr_p - PW'(1);
      end

      if (byte_cnt != 2'd0) begin
        wr_p   <= wr_next;
        fr_any <= 1'b1;
        if (!holding) rel_p <= wr_next - PW'(1);
      end

      if (is_stat) begin
        fr_any <= 1'b0;
        spill  <= 1'b0;
        st_q   <= stat_in;
        if (holding && (stat_in.bad || stat_in.ovf)) begin
          wr_p <= rel_p;
        end else begin
          rel_p  <= wr_p;
          closed <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rxq_unpacker_chk.sv
module rxq_unpacker_chk (
  input logic       clk,
  input logic       rst,
  input logic       fifo_rd_req,
  input logic       fifo_rd_ack,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       out_sof,
  input logic       out_eof,
  input logic       out_zlen,
  input logic       out_good,
  input logic       out_bad,
  input logic       out_ovf
);

  always @(posedge clk) begin
    if (rst) begin
      AST_RESET_QUIET: assert (!out_valid && !fifo_rd_req); // R1
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    fifo_rd_req |=> !fifo_rd_req); // R2

  AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    fifo_rd_req |-> !out_valid); // R2

  AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    fifo_rd_ack |-> $past(fifo_rd_req)); // R3

  AST_STATUS_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_eof) |-> (!out_good && !out_bad && !out_ovf)); // R4

  AST_ZLEN_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_zlen) |-> (out_eof && out_sof && out_byte == 8'h00)); // R6

  AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) &&
      $stable(out_sof) && $stable(out_eof) && $stable(out_zlen) &&
      $stable(out_good) && $stable(out_bad) && $stable(out_ovf))); // R7

endmodule

bind rxq_unpacker rxq_unpacker_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .fifo_rd_req (fifo_rd_req),
  .fifo_rd_ack (fifo_rd_ack),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_byte    (out_byte),
  .out_sof     (out_sof),
  .out_eof     (out_eof),
  .out_zlen    (out_zlen),
  .out_good    (out_good),
  .out_bad     (out_bad),
  .out_ovf     (out_ovf)
);

// File: tb/test_rxq_unpacker.sv
`timescale 1ns/1ps
module test_rxq_unpacker;

  localparam int DEPTH = 8;
  localparam int QN    = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        drop_bad_mode = 1'b0;
  logic        fifo_rd_req;
  logic        fifo_rd_ack = 1'b0;
  logic        fifo_rd_err = 1'b0;
  logic [15:0] fifo_rd_data = 16'h0;
  logic [1:0]  fifo_rd_tag = 2'b00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_byte;
  logic        out_sof, out_eof, out_zlen, out_good, out_bad, out_ovf;

  always #2 clk = ~clk;

  rxq_unpacker #(.BUF_BYTES(DEPTH)) i_rxq_unpacker (
    .clk(clk), .rst(rst), .drop_bad_mode(drop_bad_mode),
    .fifo_rd_req(fifo_rd_req), .fifo_rd_ack(fifo_rd_ack), .fifo_rd_err(fifo_rd_err),
    .fifo_rd_data(fifo_rd_data), .fifo_rd_tag(fifo_rd_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_sof(out_sof), .out_eof(out_eof), .out_zlen(out_zlen),
    .out_good(out_good), .out_bad(out_bad), .out_ovf(out_ovf)
  );

  // FIFO model contents
  logic [15:0] q_data [QN];
  logic [1:0]  q_tag  [QN];
  int q_wr = 0, q_rd = 0;

  // expected beats
  logic [7:0] e_byte [QN];
  logic       e_sof  [QN];
  logic       e_eof  [QN];
  logic       e_zlen [QN];
  logic [2:0] e_st   [QN];
  int         e_req  [QN];
  int e_wr = 0, e_rd = 0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit tmo = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic string req_name(int r);
    case (r)
      6:  return "R6";
      9:  return "R9";
      10: return "R10";
      default: return "R3";
    endcase
  endfunction

  function automatic logic [7:0] pat(int f, int k);
    return 8'((f * 7 + k * 13 + 1) % 256);
  endfunction

  task automatic push_entry(logic [15:0] d, logic [1:0] t);
    q_data[q_wr] = d; q_tag[q_wr] = t; q_wr++;
  endtask

  task automatic push_exp(logic [7:0] b, logic s, logic e, logic z, logic [2:0] st, int r);
    e_byte[e_wr] = b; e_sof[e_wr] = s; e_eof[e_wr] = e; e_zlen[e_wr] = z;
    e_st[e_wr] = st; e_req[e_wr] = r; e_wr++;
  endtask

  // st[2]=good (bit 15), st[1]=bad (bit 14), st[0]=overflow (bit 13)
  task automatic add_frame(int f, int n, logic [2:0] st, bit drop);
    bit dropped;
    int r;
    for (int k = 0; k < n; k += 2) begin
      if (k + 1 < n) push_entry({pat(f, k + 1), pat(f, k)}, 2'b11);
      else           push_entry({8'hA5, pat(f, k)}, 2'b01);
      if ((f + k) % 5 == 0) push_entry(16'h5A3C, 2'b00);
    end
    push_entry({st, 13'd0}, 2'b10);
    dropped = drop && (st[1] || st[0]) && (n <= DEPTH - 2);
    if (n == 0)            r = 6;
    else if (!drop)        r = 3;
    else if (n > DEPTH - 2) r = 10;
    else                   r = 9;
    if (!dropped) begin
      if (n == 0) push_exp(8'h00, 1'b1, 1'b1, 1'b1, st, r);
      else for (int k = 0; k < n; k++)
        push_exp(pat(f, k), k == 0, k == n - 1, 1'b0, (k == n - 1) ? st : 3'b000, r);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) tmo <= 1'b1;
  end

  // FIFO response: one cycle after a request
  initial begin
    bit r;
    forever begin
      @(negedge clk);
      r = fifo_rd_req;
      @(posedge clk);
      #1;
      fifo_rd_ack = 1'b0;
      fifo_rd_err = 1'b0;
      fifo_rd_data = 16'hDEAD;
      fifo_rd_tag = 2'b10;
      if (r) begin
        if (q_rd < q_wr && (cyc % 11) != 0) begin
          fifo_rd_ack = 1'b1;
          fifo_rd_data = q_data[q_rd];
          fifo_rd_tag = q_tag[q_rd];
          q_rd++;
        end else begin
          fifo_rd_err = 1'b1;
        end
      end
    end
  end

  // consumer ready pattern
  initial begin
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case ((cyc / 400) % 3)
        0:       out_ready = 1'b1;
        1:       out_ready = lfsr[0];
        default: out_ready = lfsr[0] & lfsr[3];
      endcase
    end
  end

  // monitor
  initial begin
    bit       hold_prev = 1'b0;
    logic [7:0] hb;
    logic [5:0] hf;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (fifo_rd_req) begin
          n_chk++;
          if (out_valid) begin
            n_bad++;
            $display("FAIL R2: read request with out_valid=%b, expected 0", out_valid);
          end
        end
        if (hold_prev) begin
          n_chk++;
          if (!out_valid || out_byte !== hb ||
              {out_sof, out_eof, out_zlen, out_good, out_bad, out_ovf} !== hf) begin
            n_bad++;
            $display("FAIL R7: stalled beat changed: valid=%b byte=%h flags=%b, expected 1 %h %b",
                     out_valid, out_byte, {out_sof, out_eof, out_zlen, out_good, out_bad, out_ovf}, hb, hf);
          end
        end
        if (out_valid && out_ready) begin
          n_chk++;
          if (e_rd >= e_wr) begin
            n_bad++;
            $display("FAIL R8: unexpected beat byte=%h eof=%b, expected no beat", out_byte, out_eof);
          end else begin
            if (out_sof !== e_sof[e_rd]) begin
              n_bad++;
              $display("FAIL R5: beat %0d sof=%b, expected %b", e_rd, out_sof, e_sof[e_rd]);
            end else if (out_eof !== e_eof[e_rd] ||
                         {out_good, out_bad, out_ovf} !== e_st[e_rd]) begin
              n_bad++;
              $display("FAIL R4: beat %0d eof=%b st=%b, expected eof=%b st=%b",
                       e_rd, out_eof, {out_good, out_bad, out_ovf}, e_eof[e_rd], e_st[e_rd]);
            end else if (out_byte !== e_byte[e_rd] || out_zlen !== e_zlen[e_rd]) begin
              n_bad++;
              $display("FAIL %s: beat %0d byte=%h zlen=%b, expected byte=%h zlen=%b",
                       req_name(e_req[e_rd]), e_rd, out_byte, out_zlen, e_byte[e_rd], e_zlen[e_rd]);
            end
            e_rd++;
          end
        end
        hold_prev = out_valid && !out_ready;
        hb = out_byte;
        hf = {out_sof, out_eof, out_zlen, out_good, out_bad, out_ovf};
      end
    end
  end

  task automatic wait_drain();
    while (!((q_rd == q_wr) && (e_rd == e_wr)) && !tmo) @(posedge clk);
    repeat (20) @(posedge clk);
  endtask

  initial begin
    int f = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || fifo_rd_req !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: in reset valid=%b req=%b, expected 0 0", out_valid, fifo_rd_req);
    end
    @(posedge clk);
    #1 rst = 1'b0;

    // streaming mode: all lengths against all status patterns
    for (int n = 0; n < 12; n++)
      for (int s = 0; s < 8; s++) begin
        add_frame(f, n, 3'(s), 1'b0);
        f++;
      end
    wait_drain();

    // drop mode, lengths past the buffer limit (R9, R10)
    @(negedge clk);
    drop_bad_mode = 1'b1;
    repeat (10) @(posedge clk);
    for (int s = 0; s < 8; s++)
      for (int n = 0; n < 12; n++) begin
        add_frame(f, n, 3'(s), 1'b1);
        f++;
      end
    wait_drain();

    @(negedge clk);
    n_chk++;
    if (e_rd != e_wr || out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R8: beats seen %0d valid=%b, expected %0d and 0", e_rd, out_valid, e_wr);
    end
    if (tmo) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not drain, got %0d beats, expected %0d", e_rd, e_wr);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule